// File: doc/BRIEF.md
# Row-Buffered Non-Volatile Data Array Controller

This block fronts a small byte-wide non-volatile data store of `DEPTH` bytes. The store is split into rows of `ROW_BYTES` bytes. A CPU-style bus reaches both the array and one control register. The register has two live bits: a write-mode bit and a program/busy bit. With write mode off, array reads return stored bytes and array writes are dropped. With write mode on, array writes go into a one-row staging buffer and array reads leave the bus undriven.

Software commits the staged bytes by setting the program bit while write mode is already on. A timed programming cycle of `PROG_CYCLES` clocks then copies every staged byte into the row chosen by the most recent array write. When the cycle ends, hardware drops both bits. A wait request lets a running cycle finish before the block reports itself idle. A halt request stops the cycle at once, and the row being programmed is then left in an undefined state.

Top module: `eeprom_row_prog`

## Requirements
- R1: After synchronous reset the control register reads 00h, `prog_busy` and `sleep_ack` are 0, and `bus_rdata_oe` is 0.
- R2: A control register read drives `bus_rdata_oe`=1 one clock after the request. Bit 1 is write mode, bit 0 is program/busy, and bits 7:2 read 0.
- R3: An array read returns the stored byte with `bus_rdata_oe`=1 one clock after the request while write mode is 0. While write mode is 1, the response has `bus_rdata_oe`=0 and `bus_rdata`=00h.
- R4: An array write while write mode is 0 leaves the array unchanged.
- R5: An array write while write mode is 1 stages the byte at column `bus_addr[4:0]`. The programmed row is `bus_addr[6:5]` of the last such write.
- R6: Staging the same column twice before programming leaves the bitwise AND of the two bytes.
- R7: A control write with bits 1:0 = 11 starts programming only if write mode is already 1. Otherwise the program bit stays 0 and no cycle runs.
- R8: `prog_busy` is high for exactly `PROG_CYCLES` clocks, and then both control bits read 0. Only staged columns are written, and every other byte of the row keeps its value.
- R9: The staging buffer is emptied at the end of a cycle and when a control write clears write mode while it is 1.
- R10: Control writes and array writes that arrive while programming is running are ignored.
- R11: With `wait_req` high during a cycle, the cycle runs to completion. `sleep_ack` stays 0 while busy and rises one clock after busy falls.
- R12: With `halt_req` high during a cycle, the next clock shows `prog_busy`=0, write mode 0 and `sleep_ack`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Bus access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_ctrl | input | 1 | 1 = control register, 0 = array |
| bus_addr | input | ADDR_W | Array byte address |
| bus_wdata | input | 8 | Write data |
| wait_req | input | 1 | Idle request that lets a running cycle finish |
| halt_req | input | 1 | Idle request that aborts a running cycle |
| bus_rdata | output | 8 | Read data, 00h when not driven |
| bus_rdata_oe | output | 1 | Read data is driven |
| prog_busy | output | 1 | Programming cycle running |
| sleep_ack | output | 1 | Block is idle under a wait or halt request |

## Verification
The bench goes after staging order. Two writes to one column must AND; a design that overwrites would commit the later byte. Writes to two rows must program the later row; a design that keeps the first row would corrupt the wrong row. It checks that clearing write mode empties the buffer, since a leaky buffer would commit stale bytes in the next cycle. It also checks that control and array writes are ignored while programming runs, since a design that accepts them would drop write mode early or stage bytes mid-commit. Finally it counts the busy window exactly and checks the timing of `sleep_ack` under wait and under halt, so an off-by-one timer or a wait that aborts the cycle shows up at the ports.

// File: rtl/eeprog_pkg.sv
package eeprog_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [1:0] {
    RSP_IDLE    = 2'd0,
    RSP_CTRL    = 2'd1,
    RSP_ARRAY   = 2'd2,
    RSP_BLOCKED = 2'd3
  } rsp_kind_e;
endpackage

// File: rtl/eeprog_array.sv
module eeprog_array #(
  parameter int unsigned DEPTH  = 128,
  parameter int unsigned ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata
);
  logic [7:0] mem [DEPTH];
  logic [7:0] rdata_q;

  // single-port, read-first; maps onto one block RAM
  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata_q <= mem[addr];
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/eeprog_latch.sv
module eeprog_latch #(
  parameter int unsigned ROW_BYTES = 32,
  parameter int unsigned ADDR_W    = 7,
  localparam int unsigned COL_W    = $clog2(ROW_BYTES),
  localparam int unsigned ROW_W    = ADDR_W - COL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              clr,
  input  logic [COL_W-1:0]  rd_idx,
  output logic [7:0]        rd_data,
  output logic              rd_valid,
  output logic [ROW_W-1:0]  row_o
);
  logic [7:0]           data_q [ROW_BYTES];
  logic [ROW_BYTES-1:0] valid_q;
  logic [ROW_W-1:0]     row_q;
  logic [COL_W-1:0]     wr_col;

  assign wr_col = wr_addr[COL_W-1:0];

  // one byte register per column; a second write ANDs into the first
  for (genvar i = 0; i < ROW_BYTES; i++) begin : g_col
    always_ff @(posedge clk) begin
      if (wr_en && wr_col == COL_W'(i)) begin
        data_q[i] <= valid_q[i] ? (data_q[i] & wr_data) : wr_data;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      valid_q <= '0;
    end else if (wr_en) begin
      valid_q[wr_col] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      row_q <= '0;
    end else if (wr_en) begin
      row_q <= wr_addr[ADDR_W-1:COL_W];
    end
  end

  assign rd_data  = data_q[rd_idx];
  assign rd_valid = valid_q[rd_idx];
  assign row_o    = row_q;

  // R9: staging and clearing never share a cycle
  p_stage_clear_excl_r9: assert property (@(posedge clk) disable iff (rst)
    clr |-> !wr_en);
endmodule

// File: rtl/eeprog_ctrl.sv
module eeprog_ctrl #(
  parameter int unsigned ROW_BYTES   = 32,
  parameter int unsigned PROG_CYCLES = 40,
  localparam int unsigned COL_W      = $clog2(ROW_BYTES),
  localparam int unsigned IDX_W      = COL_W + 1,
  localparam int unsigned CNT_W      = (PROG_CYCLES > 1) ? $clog2(PROG_CYCLES) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_wr,
  input  logic [1:0]       reg_cmd,
  input  logic             wait_req,
  input  logic             halt_req,
  output logic             lat_o,
  output logic             pgm_o,
  output logic             clr_o,
  output logic             slot_o,
  output logic [COL_W-1:0] slot_idx_o,
  output logic             sleep_ack_o
);
  logic             lat_q, pgm_q, sleep_q;
  logic [CNT_W-1:0] cnt_q;
  logic [IDX_W-1:0] idx_q;
  logic             start, fall, finish, abort;

  always_comb begin
    start  = reg_wr && !pgm_q && lat_q && reg_cmd[1] && reg_cmd[0];
    fall   = reg_wr && !pgm_q && lat_q && !reg_cmd[1];
    finish = pgm_q && !halt_req && (cnt_q == '0);
    abort  = pgm_q && halt_req;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lat_q   <= 1'b0;
      pgm_q   <= 1'b0;
      cnt_q   <= '0;
      idx_q   <= '0;
      sleep_q <= 1'b0;
    end else begin
      sleep_q <= halt_req || (wait_req && !pgm_q);
      if (abort || finish) begin
        pgm_q <= 1'b0;
        lat_q <= 1'b0;
      end else if (pgm_q) begin
        cnt_q <= cnt_q - 1'b1;
        if (idx_q < IDX_W'(ROW_BYTES)) idx_q <= idx_q + 1'b1;
      end else if (reg_wr) begin
        lat_q <= reg_cmd[1];
        if (start) begin
          pgm_q <= 1'b1;
          cnt_q <= CNT_W'(PROG_CYCLES - 1);
          idx_q <= '0;
        end
      end
    end
  end

  assign lat_o       = lat_q;
  assign pgm_o       = pgm_q;
  assign clr_o       = abort || finish || fall;
  assign slot_o      = pgm_q && !halt_req && (idx_q < IDX_W'(ROW_BYTES));
  assign slot_idx_o  = idx_q[COL_W-1:0];
  assign sleep_ack_o = sleep_q;

  // R7: a cycle only begins from write mode
  p_start_from_latch_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(pgm_q) |-> $past(lat_q));
  // R10: write mode cannot drop while busy without an end or abort
  p_busy_holds_latch_r10: assert property (@(posedge clk) disable iff (rst)
    pgm_q |-> lat_q);
  // R11: a wait request does not cut the cycle short
  p_wait_continues_r11: assert property (@(posedge clk) disable iff (rst)
    (pgm_q && wait_req && !halt_req && cnt_q != '0) |=> pgm_q);
  // R12: halt ends the cycle on the next edge
  p_halt_aborts_r12: assert property (@(posedge clk) disable iff (rst)
    (pgm_q && halt_req) |=> (!pgm_q && !lat_q && sleep_q));
endmodule

// File: rtl/eeprom_row_prog.sv
module eeprom_row_prog #(
  parameter int unsigned DEPTH       = 128,
  parameter int unsigned ROW_BYTES   = 32,
  parameter int unsigned PROG_CYCLES = 40,
  localparam int unsigned ADDR_W     = $clog2(DEPTH),
  localparam int unsigned COL_W      = $clog2(ROW_BYTES),
  localparam int unsigned ROW_W      = ADDR_W - COL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic              bus_ctrl,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  input  logic              wait_req,
  input  logic              halt_req,
  output logic [7:0]        bus_rdata,
  output logic              bus_rdata_oe,
  output logic              prog_busy,
  output logic              sleep_ack
);
  import eeprog_pkg::*;

  logic             lat, pgm, clr, slot;
  logic [COL_W-1:0] slot_idx;
  logic [ROW_W-1:0] lrow;
  logic [7:0]       lat_data, mem_rdata;
  logic             lat_valid;
  logic             reg_wr, stage_wr, arr_rd, ctrl_rd, commit_we;
  logic [ADDR_W-1:0] mem_addr;
  rsp_kind_e        rsp_q;
  logic [BYTE_W-1:0] snap_q;

  always_comb begin
    reg_wr    = bus_req && bus_we && bus_ctrl;
    stage_wr  = bus_req && bus_we && !bus_ctrl && lat && !pgm;
    arr_rd    = bus_req && !bus_we && !bus_ctrl;
    ctrl_rd   = bus_req && !bus_we && bus_ctrl;
    commit_we = slot && lat_valid;
    mem_addr  = slot ? {lrow, slot_idx} : bus_addr;
  end

  eeprog_ctrl #(.ROW_BYTES(ROW_BYTES), .PROG_CYCLES(PROG_CYCLES)) u_ctrl (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_cmd(bus_wdata[1:0]),
    .wait_req(wait_req), .halt_req(halt_req),
    .lat_o(lat), .pgm_o(pgm), .clr_o(clr), .slot_o(slot),
    .slot_idx_o(slot_idx), .sleep_ack_o(sleep_ack)
  );

  eeprog_latch #(.ROW_BYTES(ROW_BYTES), .ADDR_W(ADDR_W)) u_latch (
    .clk(clk), .rst(rst), .wr_en(stage_wr), .wr_addr(bus_addr),
    .wr_data(bus_wdata), .clr(clr), .rd_idx(slot_idx),
    .rd_data(lat_data), .rd_valid(lat_valid), .row_o(lrow)
  );

  eeprog_array #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_array (
    .clk(clk), .we(commit_we), .addr(mem_addr), .wdata(lat_data),
    .rdata(mem_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_q  <= RSP_IDLE;
      snap_q <= '0;
    end else begin
      if (ctrl_rd)     rsp_q <= RSP_CTRL;
      else if (arr_rd) rsp_q <= lat ? RSP_BLOCKED : RSP_ARRAY;
      else             rsp_q <= RSP_IDLE;
      snap_q <= {{(BYTE_W-2){1'b0}}, lat, pgm};
    end
  end

  always_comb begin
    bus_rdata_oe = 1'b0;
    bus_rdata    = '0;
    case (rsp_q)
      RSP_CTRL:  begin bus_rdata_oe = 1'b1; bus_rdata = snap_q;    end
      RSP_ARRAY: begin bus_rdata_oe = 1'b1; bus_rdata = mem_rdata; end
      default:   ;
    endcase
  end

  assign prog_busy = pgm;

  // R3: array reads in write mode never drive the bus
  p_blocked_read_r3: assert property (@(posedge clk) disable iff (rst)
    (arr_rd && lat) |=> (!bus_rdata_oe && bus_rdata == 8'h00));
  // R2: register reads answer next cycle with upper bits clear
  p_ctrl_read_r2: assert property (@(posedge clk) disable iff (rst)
    ctrl_rd |=> (bus_rdata_oe && bus_rdata[7:2] == 6'd0));
  // R4: the array is only written by a running cycle
  p_commit_only_busy_r4: assert property (@(posedge clk) disable iff (rst)
    commit_we |-> prog_busy);
endmodule

// File: tb/eeprom_row_prog_test.sv
`timescale 1ns/1ps
module eeprom_row_prog_test;
  localparam int DEPTH = 128;
  localparam int ROWB  = 32;
  localparam int PC    = 40;

  logic       clk = 1'b0;
  logic       rst;
  logic       bus_req, bus_we, bus_ctrl, wait_req, halt_req;
  logic [6:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata;
  logic       bus_rdata_oe, prog_busy, sleep_ack;

  eeprom_row_prog #(.DEPTH(DEPTH), .ROW_BYTES(ROWB), .PROG_CYCLES(PC)) uut (
    .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we),
    .bus_ctrl(bus_ctrl), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .wait_req(wait_req), .halt_req(halt_req), .bus_rdata(bus_rdata),
    .bus_rdata_oe(bus_rdata_oe), .prog_busy(prog_busy), .sleep_ack(sleep_ack)
  );

  always #4 clk = ~clk;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [7:0] m_mem [DEPTH];
  logic [7:0] lbuf [ROWB];
  bit         lval [ROWB];
  logic [1:0] lrow;
  bit         m_lat, m_busy;

  logic [8:0] exp_q [$];
  string      tag_q [$];
  bit         pend;

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 37 + 11) & 8'hFF);
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: compares read responses against the scoreboard queue
  always @(posedge clk) pend <= bus_req && !bus_we;
  always @(negedge clk) begin
    if (pend && !rst) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "scoreboard-underflow", 0, 1);
      end else begin
        logic [8:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check({bus_rdata_oe, bus_rdata} === e, t, {bus_rdata_oe, bus_rdata}, e);
      end
    end
  end

  task automatic idle_bus();
    bus_req = 0; bus_we = 0; bus_ctrl = 0; bus_addr = '0; bus_wdata = '0;
  endtask

  task automatic clear_model_latch();
    for (int c = 0; c < ROWB; c++) lval[c] = 0;
  endtask

  task automatic reg_write(input logic [7:0] v);
    bus_req = 1; bus_we = 1; bus_ctrl = 1; bus_wdata = v;
    if (!m_busy) begin
      if (m_lat && !v[1]) clear_model_latch();
      if (m_lat && v[1] && v[0]) m_busy = 1;
      m_lat = v[1];
    end
    @(negedge clk);
    idle_bus();
  endtask

  task automatic arr_write(input logic [6:0] a, input logic [7:0] d);
    bus_req = 1; bus_we = 1; bus_ctrl = 0; bus_addr = a; bus_wdata = d;
    if (m_lat && !m_busy) begin
      lrow = a[6:5];
      if (lval[a[4:0]]) lbuf[a[4:0]] = lbuf[a[4:0]] & d;
      else lbuf[a[4:0]] = d;
      lval[a[4:0]] = 1;
    end
    @(negedge clk);
    idle_bus();
  endtask

  task automatic arr_read(input logic [6:0] a, input string tag);
    bus_req = 1; bus_we = 0; bus_ctrl = 0; bus_addr = a;
    exp_q.push_back(m_lat ? 9'h000 : {1'b1, m_mem[a]});
    tag_q.push_back(tag);
    @(negedge clk);
    idle_bus();
  endtask

  task automatic reg_read(input logic [7:0] e, input string tag);
    bus_req = 1; bus_we = 0; bus_ctrl = 1;
    exp_q.push_back({1'b1, e});
    tag_q.push_back(tag);
    @(negedge clk);
    idle_bus();
  endtask

  // waits out a cycle, returns its length, applies the commit to the model
  task automatic finish_prog(output int cycles);
    cycles = 0;
    while (prog_busy) begin
      cycles++;
      @(negedge clk);
    end
    for (int c = 0; c < ROWB; c++)
      if (lval[c]) m_mem[{lrow, 5'(c)}] = lbuf[c];
    clear_model_latch();
    m_lat = 0; m_busy = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int n;
    bit ok;
    rst = 1; wait_req = 0; halt_req = 0; idle_bus();
    m_lat = 0; m_busy = 0; lrow = 0; clear_model_latch();
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);

    // R1: reset state
    check(prog_busy == 0 && sleep_ack == 0 && bus_rdata_oe == 0, "R1 idle outputs",
          {prog_busy, sleep_ack, bus_rdata_oe}, 0);
    reg_read(8'h00, "R1 ctrl after reset");

    // R5 R8: fill every row through the staging buffer
    for (int r = 0; r < 4; r++) begin
      reg_write(8'h02);
      for (int c = 0; c < ROWB; c++) arr_write(7'(r * ROWB + c), pat(r * ROWB + c));
      reg_write(8'h03);
      finish_prog(n);
      check(n == PC, "R8 busy length", n, PC);
    end
    reg_read(8'h00, "R8 both bits clear");
    for (int a = 0; a < DEPTH; a++) arr_read(7'(a), "R3 R5 read back");

    // R4: write in read mode is dropped
    arr_write(7'h05, 8'h00);
    arr_read(7'h05, "R4 write ignored");

    // R2 R3: write mode visible, array read blocked
    reg_write(8'h02);
    reg_read(8'h02, "R2 ctrl shows write mode");
    arr_read(7'h07, "R3 blocked read");

    // R6 R5 R8: AND merge, last row wins, unstaged bytes kept
    arr_write(7'h23, 8'hF0);
    arr_write(7'h43, 8'h3C);
    arr_write(7'h4A, 8'h55);
    reg_write(8'h03);
    finish_prog(n);
    arr_read(7'h43, "R6 AND merge");
    arr_read(7'h4A, "R5 row from last write");
    arr_read(7'h23, "R5 earlier row untouched");
    arr_read(7'h44, "R8 unstaged byte kept");

    // R7: program bit without write mode has no effect
    reg_write(8'h01);
    check(prog_busy == 0, "R7 no start from read mode", prog_busy, 0);
    reg_read(8'h00, "R7 ctrl after 01");
    reg_write(8'h03);
    check(prog_busy == 0, "R7 no start on entering write mode", prog_busy, 0);
    reg_read(8'h02, "R7 ctrl after 03 from read mode");
    reg_write(8'h00);

    // R9: falling write mode empties the buffer
    reg_write(8'h02);
    arr_write(7'h10, 8'h00);
    reg_write(8'h00);
    reg_write(8'h02);
    arr_write(7'h11, 8'hA5);
    reg_write(8'h03);
    finish_prog(n);
    arr_read(7'h10, "R9 cleared latch not committed");
    arr_read(7'h11, "R9 new latch committed");

    // R10: writes during busy ignored
    reg_write(8'h02);
    arr_write(7'h61, 8'h11);
    reg_write(8'h03);
    reg_write(8'h00);
    arr_write(7'h62, 8'h22);
    reg_read(8'h03, "R10 ctrl unchanged while busy");
    finish_prog(n);
    arr_read(7'h61, "R10 staged byte committed");
    arr_read(7'h62, "R10 busy write dropped");

    // R11: wait lets the cycle finish
    reg_write(8'h02);
    arr_write(7'h05, 8'h77);
    reg_write(8'h03);
    wait_req = 1;
    ok = 1; n = 0;
    while (prog_busy) begin
      if (sleep_ack) ok = 0;
      n++;
      @(negedge clk);
    end
    check(ok, "R11 no ack while busy", !ok, 0);
    check(n == PC, "R11 full cycle under wait", n, PC);
    check(sleep_ack == 0, "R11 ack lags busy", sleep_ack, 0);
    @(negedge clk);
    check(sleep_ack == 1, "R11 ack after cycle", sleep_ack, 1);
    wait_req = 0;
    for (int c = 0; c < ROWB; c++) if (lval[c]) m_mem[{lrow, 5'(c)}] = lbuf[c];
    clear_model_latch(); m_lat = 0; m_busy = 0;
    arr_read(7'h05, "R11 byte committed");

    // R12: halt aborts at once
    reg_write(8'h02);
    for (int c = 0; c < 8; c++) arr_write(7'(96 + c), 8'hC3);
    reg_write(8'h03);
    repeat (5) @(negedge clk);
    halt_req = 1;
    @(negedge clk);
    check(prog_busy == 0, "R12 busy dropped", prog_busy, 0);
    check(sleep_ack == 1, "R12 ack", sleep_ack, 1);
    halt_req = 0;
    clear_model_latch(); m_lat = 0; m_busy = 0;
    reg_read(8'h00, "R12 write mode cleared");
    arr_read(7'h20, "R12 other row intact");

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule